// File: doc/BRIEF.md
# Sine Wave Direct Digital Synthesizer

This block produces a stream of 8-bit unsigned sine samples for a resistor-ladder DAC. A 32-bit phase register moves forward by a programmable step on every cycle in which the sample-enable input is high. The eight most significant bits of the updated phase select one of 256 precomputed sine codes, and that code is placed in an output register together with a one-cycle valid strobe.

Overflow does not wrap. When adding the step to the phase would pass the top of the 32-bit range, the phase restarts at zero. The sine codes are offset and scaled so that every code lies between 0 and 200. The output frequency follows the step value: a larger step gives a faster sweep through the table.

Top module: `sine_dds`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the phase to 0 and the step to 0x001F_FFFF, clears sample to 0 and clears sample_vld to 0. With no load after reset, the first tick gives table index 0 and therefore code 100.
- R2: On each tick (sample_en high at a rising edge) where no overflow occurs, the phase becomes the old phase plus the step, taken as 32-bit values.
- R3: When the 33-bit sum of phase and step has its carry bit set, meaning the sum is above 0xFFFF_FFFF, the phase becomes exactly 0. Example: with step 0xFFFF_FFFF from phase 0, the first tick gives index 255 (code 99) and the second tick gives index 0 (code 100).
- R4: The table index is bits 31:24 of the phase value after the tick's update.
- R5: The code at index i is floor((sin(2*pi*i/255) + 1) * 100). Index 0 gives 100, index 255 gives 99, and no code exceeds 200.
- R6: sample takes the new code, and sample_vld is high, in the clock cycle right after each tick edge. sample_vld is high in a cycle only when the previous edge was a tick.
- R7: Without a tick, the phase does not advance and sample keeps its value.
- R8: A step written with tw_load does not change the phase. It is used from the next tick after the load edge. A tick at the same edge as the load still uses the previous step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | Tick: advance the phase and produce a sample |
| tw_load | input | 1 | Write tw_data into the step register |
| tw_data | input | 32 | New phase step value |
| sample | output | 8 | Registered unsigned sine code for the DAC |
| sample_vld | output | 1 | One-cycle strobe that marks a new sample |

## Verification
Each tick edge updates the phase and the output register together, so the new code and the valid strobe can be read in the cycle that follows. A step loaded at an edge first acts on the tick at the next edge, and a tick at the same edge as a load still uses the previous step. The bench changes inputs on the falling edge and reads the outputs at the next falling edge, which is half a cycle after the edge that moved them. Its model applies each tick before it applies a same-cycle load, which matches this ordering. The long run of 10,000 back-to-back ticks at the default step crosses the overflow point several times. This confirms the clear-to-zero rule at each crossing as well as in the dedicated overflow test.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int          PHASE_W  = 32;
  localparam int          ADDR_W   = 8;
  localparam int          CODE_W   = 8;
  localparam int          DEPTH    = 1 << ADDR_W;
  localparam logic [31:0] RESET_TW = 32'h001F_FFFF;
  localparam real         TWO_PI   = 6.283185307179586;
  localparam real         SCALE    = 100.0;

  // Offset-and-scaled sine code; points span 0..2*pi over depth entries.
  function automatic int sine_code(input int idx, input int depth);
    real ang;
    ang = TWO_PI * real'(idx) / real'(depth - 1);
    return $rtoi(($sin(ang) + 1.0) * SCALE);
  endfunction
endpackage

// File: rtl/dds_tuning_reg.sv
module dds_tuning_reg #(
  parameter int          W     = dds_pkg::PHASE_W,
  parameter logic [W-1:0] INIT = W'(dds_pkg::RESET_TW)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] data,
  output logic [W-1:0] tw
);
  always_ff @(posedge clk) begin
    if (rst)       tw <= INIT;
    else if (load) tw <= data;
  end

  // R8
  tw_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> tw == $past(data));

  // R8
  tw_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(tw));
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int W      = dds_pkg::PHASE_W,
  parameter int ADDR_W = dds_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [W-1:0]      tw,
  output logic [ADDR_W-1:0] addr_next,
  output logic              wrap_evt
);
  typedef struct packed {
    logic         carry;
    logic [W-1:0] value;
  } step_t;

  // Clear-on-overflow step: carry of the wide sum selects zero.
  function automatic step_t advance(input logic [W-1:0] cur, input logic [W-1:0] inc);
    logic [W:0] sum;
    step_t      r;
    sum     = {1'b0, cur} + {1'b0, inc};
    r.carry = sum[W];
    r.value = sum[W] ? '0 : sum[W-1:0];
    return r;
  endfunction

  logic [W-1:0] phase;
  step_t        stepped;
  logic [W-1:0] phase_upd;

  always_comb begin
    stepped   = advance(phase, tw);
    phase_upd = tick ? stepped.value : phase;
    wrap_evt  = tick & stepped.carry;
    addr_next = phase_upd[W-1 -: ADDR_W];
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase_upd;
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> phase == '0);

  // R7
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(phase));

  // R2
  phase_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wrap_evt) |=> phase == W'($past(phase) + $past(tw)));
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int ADDR_W = dds_pkg::ADDR_W,
  parameter int CODE_W = dds_pkg::CODE_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [CODE_W-1:0] code
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CODE_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam int VAL = dds_pkg::sine_code(g, DEPTH);
    assign rom[g] = CODE_W'(VAL);
  end

  assign code = rom[addr];

  // R5
  always_comb begin
    code_range_chk: assert (code <= CODE_W'(200));
  end
endmodule

// File: rtl/dds_out_reg.sv
module dds_out_reg #(
  parameter int CODE_W = dds_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] sample,
  output logic              sample_vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sample     <= '0;
      sample_vld <= 1'b0;
    end else begin
      sample_vld <= tick;
      if (tick) sample <= code;
    end
  end

  // R6
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> sample_vld && sample == $past(code));

  // R7
  sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !sample_vld && $stable(sample));
endmodule

// File: rtl/sine_dds.sv
module sine_dds #(
  parameter int PHASE_W = dds_pkg::PHASE_W,
  parameter int ADDR_W  = dds_pkg::ADDR_W,
  parameter int CODE_W  = dds_pkg::CODE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sample_en,
  input  logic               tw_load,
  input  logic [PHASE_W-1:0] tw_data,
  output logic [CODE_W-1:0]  sample,
  output logic               sample_vld
);
  logic [PHASE_W-1:0] tw;
  logic [ADDR_W-1:0]  rom_addr;
  logic [CODE_W-1:0]  rom_code;
  logic               wrap_evt;

  dds_tuning_reg #(.W(PHASE_W), .INIT(PHASE_W'(dds_pkg::RESET_TW))) u_tw (
    .clk(clk), .rst(rst), .load(tw_load), .data(tw_data), .tw(tw)
  );

  dds_phase_acc #(.W(PHASE_W), .ADDR_W(ADDR_W)) u_acc (
    .clk(clk), .rst(rst), .tick(sample_en), .tw(tw),
    .addr_next(rom_addr), .wrap_evt(wrap_evt)
  );

  dds_sine_rom #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_rom (
    .addr(rom_addr), .code(rom_code)
  );

  dds_out_reg #(.CODE_W(CODE_W)) u_out (
    .clk(clk), .rst(rst), .tick(sample_en), .code(rom_code),
    .sample(sample), .sample_vld(sample_vld)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> !sample_vld && sample == '0);
endmodule

// File: tb/sine_dds_test.sv
module sine_dds_test;
  localparam realtime HALF = 2.5ns;
  localparam logic [31:0] DEF_TW = 32'h001F_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample_en = 1'b0;
  logic        tw_load = 1'b0;
  logic [31:0] tw_data = '0;
  logic [7:0]  sample;
  logic        sample_vld;

  int checks = 0;
  int fails  = 0;

  logic [31:0] ph_m;
  logic [31:0] tw_m;
  logic [7:0]  exp_s;
  logic [7:0]  tbl [256];

  sine_dds uut (
    .clk(clk), .rst(rst), .sample_en(sample_en), .tw_load(tw_load),
    .tw_data(tw_data), .sample(sample), .sample_vld(sample_vld)
  );

  always #HALF clk = ~clk;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic build_table();
    for (int i = 0; i < 256; i++) begin
      real a;
      a = 2.0 * 3.141592653589793 * i / 255.0;
      tbl[i] = 8'($rtoi($floor(100.0 * (1.0 + $sin(a)))));
    end
  endtask

  // Called at a falling edge; applies inputs for one rising edge and checks after it.
  task automatic cyc(input bit en, input bit ld, input logic [31:0] d, input string req);
    logic [32:0] s;
    sample_en = en; tw_load = ld; tw_data = d;
    @(negedge clk);
    if (en) begin
      s = {1'b0, ph_m} + {1'b0, tw_m};
      ph_m = s[32] ? 32'd0 : s[31:0];
      exp_s = tbl[ph_m[31:24]];
    end
    if (ld) tw_m = d;
    chk(req, "sample_vld", longint'(sample_vld), longint'(en));
    chk(req, "sample", longint'(sample), longint'(exp_s));
    sample_en = 1'b0; tw_load = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; sample_en = 1'b0; tw_load = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    ph_m = '0; tw_m = DEF_TW; exp_s = '0;
    chk("R1", "sample after reset", longint'(sample), 0);
    chk("R1", "sample_vld after reset", longint'(sample_vld), 0);
  endtask

  task automatic t_reset_defaults();
    do_reset();
    cyc(1, 0, '0, "R1");
    chk("R1", "first code at default step", longint'(sample), 100);
    repeat (20) cyc(1, 0, '0, "R1");
    do_reset();
    cyc(1, 0, '0, "R1");
    chk("R1", "first code after mid-run reset", longint'(sample), 100);
  endtask

  task automatic t_table_sweep();
    do_reset();
    cyc(0, 1, 32'h0100_0000, "R8");
    for (int i = 1; i < 256; i++) begin
      cyc(1, 0, '0, "R4");
      chk("R4", "index follows updated phase", longint'(sample), longint'(tbl[i]));
      if (sample > 8'd200) chk("R5", "code above 200", longint'(sample), 200);
    end
    chk("R5", "code at index 255", longint'(sample), 99);
    cyc(1, 0, '0, "R3");
    chk("R5", "code at index 0", longint'(sample), 100);
  endtask

  task automatic t_overflow();
    do_reset();
    cyc(0, 1, 32'hFFFF_FFFF, "R8");
    cyc(1, 0, '0, "R3");
    chk("R3", "phase 0xFFFFFFFF gives index 255", longint'(sample), 99);
    cyc(1, 0, '0, "R3");
    chk("R3", "overflow clears phase to 0", longint'(sample), 100);
    cyc(1, 0, '0, "R3");
    chk("R3", "third tick back at index 255", longint'(sample), 99);
  endtask

  task automatic t_load_timing();
    do_reset();
    cyc(1, 1, 32'h4000_0000, "R8");
    chk("R8", "same-edge tick uses old step", longint'(sample), longint'(tbl[8'h00]));
    cyc(0, 1, 32'h4000_0000, "R8");
    cyc(1, 0, '0, "R8");
    chk("R8", "new step on next tick", longint'(sample), longint'(tbl[8'h40]));
    cyc(1, 0, '0, "R8");
    chk("R8", "second tick with new step", longint'(sample), longint'(tbl[8'h80]));
  endtask

  task automatic t_hold();
    do_reset();
    cyc(0, 1, 32'h2000_0000, "R8");
    cyc(1, 0, '0, "R7");
    repeat (5) cyc(0, 0, '0, "R7");
    cyc(1, 0, '0, "R7");
    chk("R7", "phase did not move while idle", longint'(sample), longint'(tbl[8'h40]));
  endtask

  task automatic t_long_run();
    do_reset();
    for (int k = 0; k < 10000; k++) cyc(1, 0, '0, "R2");
    cyc(0, 0, '0, "R6");
  endtask

  initial begin
    build_table();
    @(negedge clk);
    t_reset_defaults();
    t_table_sweep();
    t_overflow();
    t_load_timing();
    t_hold();
    t_long_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(2 * HALF * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule